// File: doc/BRIEF.md
# One-Way Privilege Lock Access Gate

This block sits between a processor's memory-mapped bus and a small group of security-sensitive registers and memories. Early boot code owns them while a privileged-mode control bit is still zero. The block watches for a write that sets that bit to one. The first such write engages a lock that only reset can release. Clearing the mode bit again, for example during a later system call, brings back the execution-resource enables but never access to the protected assets.

The bus side is a single-cycle interface: chip select, write enable, word address, write data, read data and ready. Reads are combinational and ready follows chip select in the same cycle. The block decodes four regions:

- a control region holding the mode bit, the lock status, four boot parameters and a scratch word;
- an eight-word identity memory;
- an eight-word read-only unique identifier;
- an eight-word secret store, where each word can be read only once.

A high-access input from the interrupt or system-call path, together with the live mode bit, drives the enables for ROM execution, firmware RAM and the SPI controller.

Top module: `asset_lock_gate`

## Requirements
- R1: A write to word address 0x00 with data bit 0 equal to one sets the mode bit and engages the lock. Both outputs are high from the next clock edge. Reading 0x00 returns the mode bit in bit 0, and reading 0x01 returns the lock in bit 0.
- R2: A write to 0x00 with data bit 0 equal to zero clears the mode bit and leaves the lock set. Only reset clears the lock.
- R3: No write to any other address sets the mode bit or the lock, whatever its data. This includes the scratch word at 0x06 and the read-only lock word at 0x01.
- R4: The boot parameters at 0x02 (start), 0x03 (size), 0x04 (address seed) and 0x05 (data seed) are written by bus writes while unlocked. They ignore writes while locked. They always read back at their addresses and drive their output ports.
- R5: The identity memory at 0x10 to 0x17 accepts writes only while unlocked and can be read at any time.
- R6: While unlocked, a read of 0x20+i (i from 0 to 7) returns UDI_SEED + i*0x01010101. While locked it returns zero.
- R7: While unlocked, the first read of 0x30+i returns SECRET_SEED ^ (i*0x11111111) and marks that word as used. Later reads of a used word return zero. While locked, every read returns zero and marks nothing.
- R8: The ROM-execute, firmware-RAM and SPI enables are high exactly when the mode bit is zero or the high-access input is high.
- R9: Ready equals chip select in the same cycle, whether or not the access is blocked. Read data is zero for writes, for cycles without chip select and for unmapped addresses.
- R10: A low reset at a clock edge clears the mode bit, the lock, every used flag, the boot parameters, the scratch word and the identity memory.

Top module port list:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| cs | input | 1 | Bus chip select |
| we | input | 1 | Bus write enable |
| addr | input | AW | Bus word address |
| wdata | input | DW | Bus write data |
| highAccess | input | 1 | High access level from the interrupt or system-call path |
| rdata | output | DW | Bus read data |
| ready | output | 1 | Bus ready |
| locked | output | 1 | Sticky asset lock |
| modeBit | output | 1 | Live privileged-mode bit |
| romExecEn | output | 1 | ROM execution enable |
| fwRamEn | output | 1 | Firmware RAM enable |
| spiEn | output | 1 | SPI controller enable |
| appStart | output | DW | Boot parameter: start |
| appSize | output | DW | Boot parameter: size |
| addrSeed | output | DW | Boot parameter: address scramble seed |
| dataSeed | output | DW | Boot parameter: data scramble seed |

## Verification
The assertions check on every cycle that the lock never falls outside reset and only rises after a mode write with bit 0 set. They also check that the start parameter holds while locked, that identifier reads are zero while locked, that ready tracks chip select, and that the enables stay high while the mode bit is zero. Other behaviour needs the bench's scenarios and its cycle-by-cycle reference model. That covers the read-once consumption of each secret word, that locked reads leave those words unconsumed until reset, that writes to neighbouring control words do not lock, and that identity words written before the lock keep their values after it.

// File: rtl/asset_lock_pkg.sv
package asset_lock_pkg;

  // Block numbers: address bits above the in-block word index
  localparam int BLK_CTRL   = 0;
  localparam int BLK_CDI    = 2;
  localparam int BLK_UDI    = 4;
  localparam int BLK_SECRET = 6;

  // Word offsets inside the control block
  localparam int OFF_MODE     = 0;
  localparam int OFF_LOCK     = 1;
  localparam int OFF_APPSTART = 2;
  localparam int OFF_APPSIZE  = 3;
  localparam int OFF_ADDRSEED = 4;
  localparam int OFF_DATASEED = 5;
  localparam int OFF_SCRATCH  = 6;

  // Per-word increments for the fixed identifier and secret contents
  localparam logic [31:0] UDI_STEP    = 32'h0101_0101;
  localparam logic [31:0] SECRET_STEP = 32'h1111_1111;

  typedef enum logic [2:0] {
    RG_NONE,
    RG_CTRL,
    RG_CDI,
    RG_UDI,
    RG_SECRET
  } regionT;

  typedef struct packed {
    regionT region;
    logic   rdEn;
    logic   locked;
    logic   modeBit;
    logic   wrAppStart;
    logic   wrAppSize;
    logic   wrAddrSeed;
    logic   wrDataSeed;
    logic   wrScratch;
    logic   wrCdi;
    logic   rdSecret;
  } strobeT;

endpackage

// File: rtl/asset_lock_ctrl.sv
module asset_lock_ctrl
  import asset_lock_pkg::*;
#(
  parameter int AW = 8,
  parameter int IW = 3
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          cs,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic          wrBit,
  input  logic          highAccess,
  output strobeT        strobe,
  output logic          modeBit,
  output logic          lockBit,
  output logic          romExecEn,
  output logic          fwRamEn,
  output logic          spiEn
);

  localparam int BW = AW - IW;

  logic [BW-1:0] blk;
  logic [IW-1:0] off;
  regionT        region;
  logic          wrCtrl;
  logic          modeWr;
  logic          modeReg;
  logic          lockReg;
  logic          resOpen;

  assign blk = addr[AW-1:IW];
  assign off = addr[IW-1:0];

  always_comb begin
    if (blk == BW'(BLK_CTRL))        region = RG_CTRL;
    else if (blk == BW'(BLK_CDI))    region = RG_CDI;
    else if (blk == BW'(BLK_UDI))    region = RG_UDI;
    else if (blk == BW'(BLK_SECRET)) region = RG_SECRET;
    else                             region = RG_NONE;
  end

  assign wrCtrl = cs && we && (region == RG_CTRL);
  // Only a write aimed at the mode word itself may engage the lock.
  assign modeWr = wrCtrl && (off == IW'(OFF_MODE));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeReg <= 1'b0;
      lockReg <= 1'b0;
    end else if (modeWr) begin
      modeReg <= wrBit;
      if (wrBit) lockReg <= 1'b1;
    end
  end

  always_comb begin
    strobe            = '0;
    strobe.region     = region;
    strobe.rdEn       = cs && !we;
    strobe.locked     = lockReg;
    strobe.modeBit    = modeReg;
    strobe.wrAppStart = wrCtrl && (off == IW'(OFF_APPSTART)) && !lockReg;
    strobe.wrAppSize  = wrCtrl && (off == IW'(OFF_APPSIZE))  && !lockReg;
    strobe.wrAddrSeed = wrCtrl && (off == IW'(OFF_ADDRSEED)) && !lockReg;
    strobe.wrDataSeed = wrCtrl && (off == IW'(OFF_DATASEED)) && !lockReg;
    strobe.wrScratch  = wrCtrl && (off == IW'(OFF_SCRATCH));
    strobe.wrCdi      = cs && we && (region == RG_CDI) && !lockReg;
    strobe.rdSecret   = cs && !we && (region == RG_SECRET) && !lockReg;
  end

  // Execution resources follow the live mode bit, not the lock.
  assign resOpen   = !modeReg || highAccess;
  assign romExecEn = resOpen;
  assign fwRamEn   = resOpen;
  assign spiEn     = resOpen;
  assign modeBit   = modeReg;
  assign lockBit   = lockReg;

endmodule

// File: rtl/asset_lock_dp.sv
module asset_lock_dp
  import asset_lock_pkg::*;
#(
  parameter int              DW          = 32,
  parameter int              IW          = 3,
  parameter int              N_WORDS     = 8,
  parameter logic [DW-1:0]   UDI_SEED    = 'hA5C3_0000,
  parameter logic [DW-1:0]   SECRET_SEED = 'h5EC0_0000
) (
  input  logic          clk,
  input  logic          rstN,
  input  strobeT        strobe,
  input  logic [IW-1:0] off,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic [DW-1:0] appStart,
  output logic [DW-1:0] appSize,
  output logic [DW-1:0] addrSeed,
  output logic [DW-1:0] dataSeed
);

  logic [DW-1:0]      scratchReg;
  logic [DW-1:0]      cdiMem     [N_WORDS];
  logic [DW-1:0]      udiWord    [N_WORDS];
  logic [DW-1:0]      secretWord [N_WORDS];
  logic [N_WORDS-1:0] usedFlag;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      appStart   <= '0;
      appSize    <= '0;
      addrSeed   <= '0;
      dataSeed   <= '0;
      scratchReg <= '0;
    end else begin
      if (strobe.wrAppStart) appStart   <= wdata;
      if (strobe.wrAppSize)  appSize    <= wdata;
      if (strobe.wrAddrSeed) addrSeed   <= wdata;
      if (strobe.wrDataSeed) dataSeed   <= wdata;
      if (strobe.wrScratch)  scratchReg <= wdata;
    end
  end

  for (genvar i = 0; i < N_WORDS; i++) begin : g_word
    assign udiWord[i]    = UDI_SEED + (DW'(i) * DW'(UDI_STEP));
    assign secretWord[i] = SECRET_SEED ^ (DW'(i) * DW'(SECRET_STEP));

    always_ff @(posedge clk) begin
      if (!rstN) begin
        cdiMem[i]   <= '0;
        usedFlag[i] <= 1'b0;
      end else begin
        if (strobe.wrCdi && (off == IW'(i)))    cdiMem[i]   <= wdata;
        if (strobe.rdSecret && (off == IW'(i))) usedFlag[i] <= 1'b1;
      end
    end
  end

  always_comb begin
    rdata = '0;
    if (strobe.rdEn) begin
      case (strobe.region)
        RG_CTRL: begin
          case (off)
            IW'(OFF_MODE):     rdata = DW'(strobe.modeBit);
            IW'(OFF_LOCK):     rdata = DW'(strobe.locked);
            IW'(OFF_APPSTART): rdata = appStart;
            IW'(OFF_APPSIZE):  rdata = appSize;
            IW'(OFF_ADDRSEED): rdata = addrSeed;
            IW'(OFF_DATASEED): rdata = dataSeed;
            IW'(OFF_SCRATCH):  rdata = scratchReg;
            default:           rdata = '0;
          endcase
        end
        RG_CDI:    rdata = cdiMem[off];
        RG_UDI:    rdata = strobe.locked ? '0 : udiWord[off];
        RG_SECRET: rdata = (strobe.locked || usedFlag[off]) ? '0 : secretWord[off];
        default:   rdata = '0;
      endcase
    end
  end

endmodule

// File: rtl/asset_lock_gate.sv
module asset_lock_gate
  import asset_lock_pkg::*;
#(
  parameter int            DW          = 32,
  parameter int            AW          = 8,
  parameter int            N_WORDS     = 8,
  parameter logic [DW-1:0] UDI_SEED    = 'hA5C3_0000,
  parameter logic [DW-1:0] SECRET_SEED = 'h5EC0_0000
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          cs,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  logic          highAccess,
  output logic [DW-1:0] rdata,
  output logic          ready,
  output logic          locked,
  output logic          modeBit,
  output logic          romExecEn,
  output logic          fwRamEn,
  output logic          spiEn,
  output logic [DW-1:0] appStart,
  output logic [DW-1:0] appSize,
  output logic [DW-1:0] addrSeed,
  output logic [DW-1:0] dataSeed
);

  localparam int IW = $clog2(N_WORDS);

  strobeT strobe;

  asset_lock_ctrl #(.AW(AW), .IW(IW)) u_ctrl (
    .clk(clk), .rstN(rstN), .cs(cs), .we(we), .addr(addr),
    .wrBit(wdata[0]), .highAccess(highAccess), .strobe(strobe),
    .modeBit(modeBit), .lockBit(locked), .romExecEn(romExecEn),
    .fwRamEn(fwRamEn), .spiEn(spiEn)
  );

  asset_lock_dp #(
    .DW(DW), .IW(IW), .N_WORDS(N_WORDS),
    .UDI_SEED(UDI_SEED), .SECRET_SEED(SECRET_SEED)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .off(addr[IW-1:0]),
    .wdata(wdata), .rdata(rdata), .appStart(appStart), .appSize(appSize),
    .addrSeed(addrSeed), .dataSeed(dataSeed)
  );

  assign ready = cs;

endmodule

// File: rtl/asset_lock_checker.sv
module asset_lock_checker #(
  parameter int DW = 32,
  parameter int AW = 8
) (
  input logic          clk,
  input logic          rstN,
  input logic          cs,
  input logic          we,
  input logic [AW-1:0] addr,
  input logic [DW-1:0] wdata,
  input logic [DW-1:0] rdata,
  input logic          ready,
  input logic          locked,
  input logic          modeBit,
  input logic          romExecEn,
  input logic          fwRamEn,
  input logic          spiEn,
  input logic [DW-1:0] appStart
);

  logic udiRead;
  assign udiRead = cs && !we && (addr >= AW'(8'h20)) && (addr <= AW'(8'h27));

  AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    locked |=> locked); // R2

  AST_LOCK_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(locked) |-> $past(cs && we && (addr == '0) && wdata[0])); // R3

  AST_LOCK_WITH_MODE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(modeBit) |-> locked); // R1

  AST_START_HELD: assert property (@(posedge clk) disable iff (!rstN)
    locked |=> $stable(appStart)); // R4

  AST_UDI_HIDDEN: assert property (@(posedge clk) disable iff (!rstN)
    (locked && udiRead) |-> (rdata == '0)); // R6

  AST_READY_SAME: assert property (@(posedge clk) disable iff (!rstN)
    cs |-> ready); // R9

  AST_ENABLES_OPEN: assert property (@(posedge clk) disable iff (!rstN)
    !modeBit |-> (romExecEn && fwRamEn && spiEn)); // R8

endmodule

bind asset_lock_gate asset_lock_checker #(.DW(DW), .AW(AW)) u_chk (
  .clk(clk), .rstN(rstN), .cs(cs), .we(we), .addr(addr), .wdata(wdata),
  .rdata(rdata), .ready(ready), .locked(locked), .modeBit(modeBit),
  .romExecEn(romExecEn), .fwRamEn(fwRamEn), .spiEn(spiEn), .appStart(appStart)
);

// File: tb/asset_lock_gate_bench.sv
`timescale 1ns/100ps
module asset_lock_gate_bench;

  localparam logic [31:0] UDI_SEED    = 32'hA5C3_0000;
  localparam logic [31:0] SECRET_SEED = 32'h5EC0_0000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cs = 1'b0, we = 1'b0, highAccess = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata, appStart, appSize, addrSeed, dataSeed;
  logic        ready, locked, modeBit, romExecEn, fwRamEn, spiEn;

  always #2.5 clk = ~clk;

  asset_lock_gate #(.UDI_SEED(UDI_SEED), .SECRET_SEED(SECRET_SEED)) u_asset_lock_gate (
    .clk(clk), .rstN(rstN), .cs(cs), .we(we), .addr(addr), .wdata(wdata),
    .highAccess(highAccess), .rdata(rdata), .ready(ready), .locked(locked),
    .modeBit(modeBit), .romExecEn(romExecEn), .fwRamEn(fwRamEn), .spiEn(spiEn),
    .appStart(appStart), .appSize(appSize), .addrSeed(addrSeed), .dataSeed(dataSeed)
  );

  // Behavioural reference model
  bit          mMode, mLock, modelValid, done;
  logic [31:0] mParam [4];
  logic [31:0] mScratch;
  logic [31:0] mCdi [8];
  bit          mUsed [8];
  int          checks, errors;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] expRead(logic c, logic w, logic [7:0] a);
    logic [2:0] o = a[2:0];
    if (!c || w) return '0;
    case (a[7:3])
      5'd0: case (o)
              3'd0: return {31'b0, mMode};
              3'd1: return {31'b0, mLock};
              3'd2, 3'd3, 3'd4, 3'd5: return mParam[o - 3'd2];
              3'd6: return mScratch;
              default: return '0;
            endcase
      5'd2: return mCdi[o];
      5'd4: return mLock ? '0 : UDI_SEED + 32'(o) * 32'h0101_0101;
      5'd6: return (mLock || mUsed[o]) ? '0 : SECRET_SEED ^ (32'(o) * 32'h1111_1111);
      default: return '0;
    endcase
  endfunction

  function automatic string tagFor(logic [7:0] a);
    case (a[7:3])
      5'd0: return "R4";
      5'd2: return "R5";
      5'd4: return "R6";
      5'd6: return "R7";
      default: return "R9";
    endcase
  endfunction

  task automatic modelEdge();
    logic [2:0] o = addr[2:0];
    if (!rstN) begin
      mMode = 0; mLock = 0; mScratch = '0;
      for (int i = 0; i < 4; i++) mParam[i] = '0;
      for (int i = 0; i < 8; i++) begin mCdi[i] = '0; mUsed[i] = 0; end
      modelValid = 1;
    end else if (cs && we) begin
      if (addr == 8'h00) begin
        mMode = wdata[0];
        if (wdata[0]) mLock = 1;
      end else if (addr[7:3] == 5'd0 && o >= 3'd2 && o <= 3'd5) begin
        if (!mLock) mParam[o - 3'd2] = wdata;
      end else if (addr == 8'h06) mScratch = wdata;
      else if (addr[7:3] == 5'd2 && !mLock) mCdi[o] = wdata;
    end else if (cs && !we && addr[7:3] == 5'd6 && !mLock) mUsed[o] = 1;
  endtask

  task automatic step(logic c, logic w, logic [7:0] a, logic [31:0] d, logic h);
    @(negedge clk);
    if (modelValid) begin
      chk("R2", {31'b0, locked}, {31'b0, mLock});
      chk("R1", {31'b0, modeBit}, {31'b0, mMode});
      chk("R4", appStart, mParam[0]);
      chk("R4", appSize,  mParam[1]);
      chk("R4", addrSeed, mParam[2]);
      chk("R4", dataSeed, mParam[3]);
      chk("R8", {29'b0, romExecEn, fwRamEn, spiEn}, (!mMode || highAccess) ? 32'd7 : 32'd0);
    end
    cs = c; we = w; addr = a; wdata = d; highAccess = h;
    #1;
    if (modelValid) begin
      chk("R9", {31'b0, ready}, {31'b0, c});
      chk(tagFor(a), rdata, expRead(c, w, a));
    end
    @(posedge clk);
    modelEdge();
    #1;
  endtask

  task automatic doReset();
    rstN = 1'b0;
    step(0, 0, 8'h00, '0, 0);
    step(0, 0, 8'h00, '0, 0);
    rstN = 1'b1;
  endtask

  initial begin
    doReset();
    chk("R10", {31'b0, locked}, 32'd0);
    chk("R10", appStart, 32'd0);

    // Unlocked: parameters, identity memory, identifier, secrets
    step(1, 1, 8'h02, 32'h0000_1000, 0);
    step(1, 1, 8'h03, 32'h0000_0200, 0);
    step(1, 1, 8'h04, 32'hDEAD_BEEF, 0);
    step(1, 1, 8'h05, 32'h1234_5678, 0);
    for (int i = 2; i <= 5; i++) step(1, 0, 8'(i), '0, 0);
    for (int i = 0; i < 8; i++) step(1, 1, 8'h10 + 8'(i), 32'hC0DE_0000 + 32'(i), 0);
    for (int i = 0; i < 8; i++) step(1, 0, 8'h10 + 8'(i), '0, 0);
    for (int i = 0; i < 8; i++) step(1, 0, 8'h20 + 8'(i), '0, 0);
    step(1, 0, 8'h32, '0, 0);
    chk("R7", rdata, 32'd0);                 // same word now consumed
    step(1, 0, 8'h32, '0, 0);
    step(0, 0, 8'h32, '0, 0);                // no chip select
    step(1, 0, 8'h3F, '0, 0);                // unmapped

    // Neighbouring writes must not lock
    step(1, 1, 8'h06, 32'hFFFF_FFFF, 0);
    step(1, 1, 8'h01, 32'h0000_0001, 0);
    step(1, 1, 8'h07, 32'h0000_0001, 0);
    chk("R3", {31'b0, locked}, 32'd0);
    chk("R3", {31'b0, modeBit}, 32'd0);
    step(1, 0, 8'h06, '0, 0);

    // Engage the lock
    step(1, 1, 8'h00, 32'h0000_0001, 0);
    chk("R1", {31'b0, locked}, 32'd1);
    step(1, 0, 8'h00, '0, 0);
    step(1, 0, 8'h01, '0, 1);
    step(0, 0, 8'h00, '0, 0);
    step(1, 1, 8'h02, 32'hBAD0_0002, 0);
    step(1, 1, 8'h05, 32'hBAD0_0005, 0);
    step(1, 1, 8'h13, 32'hBAD0_0013, 1);
    for (int i = 0; i < 8; i++) step(1, 0, 8'h10 + 8'(i), '0, 0);
    step(1, 0, 8'h24, '0, 0);
    step(1, 0, 8'h35, '0, 0);
    chk("R7", rdata, 32'd0);

    // Clear the mode bit: lock stays, resources return
    step(1, 1, 8'h00, 32'h0000_0000, 0);
    chk("R2", {31'b0, locked}, 32'd1);
    chk("R2", {31'b0, modeBit}, 32'd0);
    step(1, 1, 8'h03, 32'hBAD0_0003, 0);
    step(1, 1, 8'h16, 32'hBAD0_0016, 0);
    step(1, 0, 8'h16, '0, 0);
    step(1, 0, 8'h27, '0, 0);
    step(1, 0, 8'h30, '0, 0);
    step(0, 0, 8'h00, '0, 0);

    // Reset restores access and the secret flags
    doReset();
    chk("R10", {31'b0, locked}, 32'd0);
    chk("R10", appSize, 32'd0);
    step(1, 0, 8'h35, '0, 0);
    chk("R10", rdata, 32'd0);                // consumed by that read
    step(1, 0, 8'h32, '0, 0);
    step(1, 0, 8'h10, '0, 0);
    step(1, 0, 8'h23, '0, 0);
    step(0, 0, 8'h00, '0, 0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule